// File: doc/BRIEF.md
# Audio Processor Control Receiver (Write-Only I2C Slave)

This block sits between a two-wire I2C bus and the analog setting switches of a stereo audio processor. A host addresses it with a write, then sends any number of control bytes before STOP. Each control byte carries its own destination in a variable-length prefix of leading bits, so there is no subaddress pointer. The block decodes each byte and latches the setting it carries into a register bank.

The settings are: the stereo source, the input gain, the loudness enable, the main volume attenuation, four speaker attenuations with mute flags, and signed bass and treble levels. Volume and speaker levels come out as counts of 1.25 dB steps, gain as counts of 3.75 dB steps, and tone as signed counts of 2 dB steps. The bus lines are sampled by the system clock through two-flop synchronizers. The clock must run at least 20 times faster than the bus bit rate, and the bus runs at no more than 100 kbit/s. The block only receives: it does not support reads and never stretches SCL.

Top module: `audctl_i2c_rx`

## Requirements
- R1: After reset, volume and all speaker attenuations are 0 steps, no speaker is muted, gain is 0 steps (0 dB), loudness is off, input 1 (code 00) is selected, bass and treble are 0, and SDA is released.
- R2: After an address byte of 0x88 (7-bit address 1000100 with write bit 0), the slave pulls SDA low from the SCL fall that ends the eighth bit until the SCL fall that ends the ninth pulse.
- R3: Any other address byte, including 0x89 with the read bit set, gets no acknowledge. The bus is then ignored until the next START: later bytes are neither acknowledged nor applied.
- R4: In an accepted transaction, every data byte is acknowledged in the same way, and any number of data bytes may follow the address until STOP.
- R5: A byte of the form 00xxxxxx sets the volume to bits [5:0] in 1.25 dB steps, that is 8×coarse[5:3] + fine[2:0]. For example, 0x24 gives 36 steps (45 dB).
- R6: A byte of the form 1ssxxxxx sets one speaker to bits [4:0] in 1.25 dB steps. ss selects the speaker: 00 left-front, 01 right-front, 10 left-rear, 11 right-rear. In the packed output, speaker k occupies bits [5k+4:5k]. For example, 0xB4 sets right-front to 20 steps (25 dB).
- R7: A speaker's mute flag (output bit k) is set when its five value bits are all 1, and is cleared by any other value written to that speaker.
- R8: A byte of the form 010ggLss is the source switch. ss selects input 00, 01 or 10, and 11 leaves the selection unchanged. L=0 enables loudness. The gain output is 3 − gg in 3.75 dB steps.
- R9: A byte of the form 0110cccc sets bass and 0111cccc sets treble. Codes 0000..0111 map to −7..0 and codes 1111..1000 map to 0..+7, in signed 2 dB steps.
- R10: A byte that a START or STOP cuts short changes no setting.
- R11: STOP releases SDA and ends the transaction. A repeated START begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain) |
| src_sel_o | output | 2 | Selected stereo input (00, 01, 10) |
| in_gain_o | output | 2 | Input gain in 3.75 dB steps |
| loud_en_o | output | 1 | Loudness enabled |
| vol_att_o | output | 6 | Main volume attenuation in 1.25 dB steps |
| spk_att_o | output | 20 | Four 5-bit speaker attenuations (LF, RF, LR, RR from LSB) |
| spk_mute_o | output | 4 | Per-speaker mute flags |
| bass_o | output | 4 | Signed bass level in 2 dB steps |
| treble_o | output | 4 | Signed treble level in 2 dB steps |

## Verification
A bit counter that drifts or a wrong state after the address shows up within one byte. Either the acknowledge is missing on the ninth pulse, or a setting register picks up a shifted byte, which a readback of the target field exposes right after STOP. A prefix decoded at the wrong depth writes the wrong register. This is caught by vectors that touch neighbouring prefixes (010, 0110, 0111) and then read both the targeted and the untouched fields. Ignore behaviour is checked at the ports by keeping a known volume value across a rejected address, a read address and a truncated byte.

// File: rtl/audctl_pkg.sv
// Package: shared widths, the bus state type and code-folding helpers
// for the audio control receiver.
package audctl_pkg;

    localparam int BYTE_W  = 8;
    localparam int VOL_W   = 6;
    localparam int SPK_W   = 5;
    localparam int NUM_SPK = 4;
    localparam int GAIN_W  = 2;
    localparam int SRC_W   = 2;
    localparam int TONE_W  = 4;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_ADDR,
        BS_ADDR_ACK,
        BS_DATA,
        BS_DATA_ACK,
        BS_SKIP
    } bus_state_t;

    // Convert a sign-folded tone code into a signed step count.
    function automatic logic signed [TONE_W-1:0] fold_tone(input logic [TONE_W-1:0] code);
        logic [TONE_W-1:0] r;
        if (code[TONE_W-1]) r = 4'd15 - code;
        else                r = code - 4'd7;
        return $signed(r);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clock domain through a STAGES-deep
// synchronizer and flags SCL edges plus START and STOP conditions.
// Assumes the system clock is at least 20x the bus bit rate, so that
// both lines settle between edges.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Shift both bus lines through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    // Derive edges and bus conditions from the synchronized lines.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_d     = scl_pipe[STAGES];
        sda_d     = sda_pipe[STAGES];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_wr_engine.sv
// Module: i2c_wr_engine
// Write-only byte engine: matches the device address, acknowledges
// the address and each data byte, and pulses wr_stb with every
// complete data byte. Assumes synchronized lines and single-cycle edge
// flags from i2c_line_sync. Does not stretch SCL.
module i2c_wr_engine
    import audctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_pull,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_byte
);

    localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
    localparam logic [CNT_W-1:0]  FULL    = CNT_W'(BYTE_W);

    bus_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;

    // Bus state machine: shifts bits, drives the acknowledge and issues byte strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= BS_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
            wr_byte  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                state    <= BS_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= BS_IDLE;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    BS_ADDR, BS_DATA: begin
                        if (scl_rise && bit_cnt != FULL) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            if (state == BS_ADDR) begin
                                if (shreg == ADDR_WR) begin
                                    sda_pull <= 1'b1;
                                    state    <= BS_ADDR_ACK;
                                end else begin
                                    state    <= BS_SKIP;
                                end
                            end else begin
                                wr_stb   <= 1'b1;
                                wr_byte  <= shreg;
                                sda_pull <= 1'b1;
                                state    <= BS_DATA_ACK;
                            end
                        end
                    end
                    BS_ADDR_ACK, BS_DATA_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= BS_DATA;
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/audctl_setting_bank.sv
// Module: audctl_setting_bank
// Decodes each self-routing control byte by its leading bits and
// updates the addressed setting register. Assumes wr_stb is a
// single-cycle pulse with wr_byte valid in the same cycle.
module audctl_setting_bank
    import audctl_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_stb,
    input  logic [BYTE_W-1:0]         wr_byte,
    output logic [SRC_W-1:0]          src_sel,
    output logic [GAIN_W-1:0]         in_gain,
    output logic                      loud_en,
    output logic [VOL_W-1:0]          vol_att,
    output logic [NUM_SPK*SPK_W-1:0]  spk_att,
    output logic [NUM_SPK-1:0]        spk_mute,
    output logic signed [TONE_W-1:0]  bass,
    output logic signed [TONE_W-1:0]  treble
);

    logic hit_vol;
    logic hit_spk;
    logic hit_sw;
    logic hit_bass;
    logic hit_treb;

    // Prefix decode: the longest prefixes are checked against their full width.
    always_comb begin
        hit_vol  = wr_stb && (wr_byte[7:6] == 2'b00);
        hit_spk  = wr_stb && wr_byte[7];
        hit_sw   = wr_stb && (wr_byte[7:5] == 3'b010);
        hit_bass = wr_stb && (wr_byte[7:4] == 4'b0110);
        hit_treb = wr_stb && (wr_byte[7:4] == 4'b0111);
    end

    // Main volume register.
    always_ff @(posedge clk) begin
        if (!rst_n)       vol_att <= '0;
        else if (hit_vol) vol_att <= wr_byte[VOL_W-1:0];
    end

    // Source switch register: the reserved input code keeps the old source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel <= '0;
            in_gain <= '0;
            loud_en <= 1'b0;
        end else if (hit_sw) begin
            if (wr_byte[1:0] != 2'b11) src_sel <= wr_byte[1:0];
            loud_en <= ~wr_byte[2];
            in_gain <= ~wr_byte[4:3];
        end
    end

    // Tone registers, unfolded into signed step counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bass   <= '0;
            treble <= '0;
        end else begin
            if (hit_bass) bass   <= fold_tone(wr_byte[TONE_W-1:0]);
            if (hit_treb) treble <= fold_tone(wr_byte[TONE_W-1:0]);
        end
    end

    // One attenuation register and mute flag per speaker, selected by bits [6:5].
    for (genvar k = 0; k < NUM_SPK; k++) begin : g_spk
        logic sel_k;
        assign sel_k = hit_spk && (wr_byte[6:5] == 2'(k));

        // Speaker k attenuation and mute latch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                spk_att[k*SPK_W +: SPK_W] <= '0;
                spk_mute[k]               <= 1'b0;
            end else if (sel_k) begin
                spk_att[k*SPK_W +: SPK_W] <= wr_byte[SPK_W-1:0];
                spk_mute[k]               <= &wr_byte[SPK_W-1:0];
            end
        end
    end

endmodule

// File: rtl/audctl_i2c_rx.sv
// Module: audctl_i2c_rx (top)
// Write-only I2C receiver for audio processor settings: synchronizer,
// byte engine and setting bank. SDA is driven only as an open-drain
// pull-low through sda_pull_o.
module audctl_i2c_rx
    import audctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h44,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic [1:0]        src_sel_o,
    output logic [1:0]        in_gain_o,
    output logic              loud_en_o,
    output logic [5:0]        vol_att_o,
    output logic [19:0]       spk_att_o,
    output logic [3:0]        spk_mute_o,
    output logic signed [3:0] bass_o,
    output logic signed [3:0] treble_o
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_byte;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_wr_engine #(.DEV_ADDR(DEV_ADDR)) eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_pull  (sda_pull_o),
        .wr_stb    (wr_stb),
        .wr_byte   (wr_byte)
    );

    audctl_setting_bank bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_byte  (wr_byte),
        .src_sel  (src_sel_o),
        .in_gain  (in_gain_o),
        .loud_en  (loud_en_o),
        .vol_att  (vol_att_o),
        .spk_att  (spk_att_o),
        .spk_mute (spk_mute_o),
        .bass     (bass_o),
        .treble   (treble_o)
    );

endmodule

// File: rtl/audctl_i2c_rx_chk.sv
// Module: audctl_i2c_rx_chk
// Assertion checker bound to audctl_i2c_rx; observes ports and the
// signals passed between its submodules.
module audctl_i2c_rx_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              stop_det,
    input logic              wr_stb,
    input logic              sda_pull_o,
    input logic [1:0]        src_sel_o,
    input logic [5:0]        vol_att_o,
    input logic [19:0]       spk_att_o,
    input logic [3:0]        spk_mute_o,
    input logic signed [3:0] bass_o,
    input logic signed [3:0] treble_o
);

    AST_PULL_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s); // R2

    AST_PULL_FREED_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o); // R11

    AST_VOL_HOLDS_WITHOUT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(vol_att_o)); // R10

    AST_SRC_NEVER_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel_o != 2'b11); // R8

    AST_BASS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bass_o != 4'sb1000); // R9

    AST_TREBLE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        treble_o != 4'sb1000); // R9

    for (genvar k = 0; k < 4; k++) begin : g_mute
        AST_MUTE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            spk_mute_o[k] |-> (spk_att_o[k*5 +: 5] == 5'h1f)); // R7
    end

endmodule

bind audctl_i2c_rx audctl_i2c_rx_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .stop_det   (stop_det),
    .wr_stb     (wr_stb),
    .sda_pull_o (sda_pull_o),
    .src_sel_o  (src_sel_o),
    .vol_att_o  (vol_att_o),
    .spk_att_o  (spk_att_o),
    .spk_mute_o (spk_mute_o),
    .bass_o     (bass_o),
    .treble_o   (treble_o)
);

// File: tb/audctl_i2c_rx_tb_top.sv
// Bench for audctl_i2c_rx: a table of one-byte writes with the expected
// field value, then directed tests for reset, address rejection,
// truncation, repeated START and multi-byte transfers.
module audctl_i2c_rx_tb_top;

    localparam int Q  = 10;
    localparam int NV = 19;

    // Each vector: {data byte, field selector, expected value (signed 8-bit)}.
    // Selectors: 0 vol, 1..4 speaker LF/RF/LR/RR, 5 mute vector, 6 src, 7 loud, 8 gain, 9 bass, 10 treble.
    localparam logic [19:0] VEC [NV] = '{
        {8'h24, 4'd0,  8'd36},   // R5 example 45 dB
        {8'h3F, 4'd0,  8'd63},   // R5 maximum
        {8'h84, 4'd1,  8'd4},    // R6 LF
        {8'hB4, 4'd2,  8'd20},   // R6 RF 25 dB
        {8'hD7, 4'd3,  8'd23},   // R6 LR
        {8'hFF, 4'd4,  8'd31},   // R6 RR
        {8'hFF, 4'd5,  8'd8},    // R7 RR muted only
        {8'hE0, 4'd5,  8'd0},    // R7 mute cleared
        {8'h49, 4'd6,  8'd1},    // R8 input 2
        {8'h49, 4'd7,  8'd1},    // R8 loudness on
        {8'h49, 4'd8,  8'd2},    // R8 gain +7.5 dB
        {8'h4B, 4'd6,  8'd1},    // R8 reserved input keeps 2
        {8'h5F, 4'd8,  8'd0},    // R8 gain 0 dB
        {8'h5F, 4'd7,  8'd0},    // R8 loudness off
        {8'h62, 4'd9,  8'hFB},   // R9 bass -10 dB
        {8'h68, 4'd9,  8'd7},    // R9 bass +14 dB
        {8'h7F, 4'd10, 8'd0},    // R9 treble 1111 flat
        {8'h70, 4'd10, 8'hF9},   // R9 treble -14 dB
        {8'h7A, 4'd10, 8'd5}     // R9 treble +10 dB
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_o;
    logic sda_line;
    logic [1:0]        src_sel_o;
    logic [1:0]        in_gain_o;
    logic              loud_en_o;
    logic [5:0]        vol_att_o;
    logic [19:0]       spk_att_o;
    logic [3:0]        spk_mute_o;
    logic signed [3:0] bass_o;
    logic signed [3:0] treble_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    assign sda_line = sda_m & ~sda_pull_o;

    always #4 clk = ~clk;

    audctl_i2c_rx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull_o),
        .src_sel_o  (src_sel_o),
        .in_gain_o  (in_gain_o),
        .loud_en_o  (loud_en_o),
        .vol_att_o  (vol_att_o),
        .spk_att_o  (spk_att_o),
        .spk_mute_o (spk_mute_o),
        .bass_o     (bass_o),
        .treble_o   (treble_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_m) begin
            sda_m = 1'b1; wait_q();
            scl_m = 1'b1; wait_q();
        end
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
        wait_q();
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = v[7-i]; wait_q();
            scl_m = 1'b1;   wait_q(); wait_q();
            scl_m = 1'b0;   wait_q();
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        send_bits(v, 8);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        ack = ~sda_line;
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    function automatic int field(input int sel);
        case (sel)
            0:       return int'(vol_att_o);
            1, 2, 3, 4: return int'(spk_att_o[(sel-1)*5 +: 5]);
            5:       return int'(spk_mute_o);
            6:       return int'(src_sel_o);
            7:       return int'(loud_en_o);
            8:       return int'(in_gain_o);
            9:       return int'(bass_o);
            default: return int'(treble_o);
        endcase
    endfunction

    function automatic string req_of(input int sel);
        if (sel == 0) return "R5";
        if (sel <= 4) return "R6";
        if (sel == 5) return "R7";
        if (sel <= 8) return "R8";
        return "R9";
    endfunction

    initial begin
        logic ack;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk("R1", "vol",      int'(vol_att_o),  0);
        chk("R1", "spk",      int'(spk_att_o),  0);
        chk("R1", "mute",     int'(spk_mute_o), 0);
        chk("R1", "gain",     int'(in_gain_o),  0);
        chk("R1", "loud",     int'(loud_en_o),  0);
        chk("R1", "src",      int'(src_sel_o),  0);
        chk("R1", "bass",     int'(bass_o),     0);
        chk("R1", "treble",   int'(treble_o),   0);
        chk("R1", "sda_pull", int'(sda_pull_o), 0);

        // Table of single-byte writes
        for (int v = 0; v < NV; v++) begin
            bus_start();
            send_byte(8'h88, ack);
            chk("R2", "address ack", int'(ack), 1);
            send_byte(VEC[v][19:12], ack);
            chk("R4", "data ack", int'(ack), 1);
            bus_stop();
            chk(req_of(int'(VEC[v][11:8])), "field",
                field(int'(VEC[v][11:8])), int'($signed(VEC[v][7:0])));
        end

        // R3: foreign address, then a volume byte that must be ignored
        bus_start();
        send_byte(8'h8A, ack);
        chk("R3", "foreign address ack", int'(ack), 0);
        send_byte(8'h00, ack);
        chk("R3", "ignored byte ack", int'(ack), 0);
        bus_stop();
        chk("R3", "vol after foreign address", int'(vol_att_o), 63);

        // R3: read bit set
        bus_start();
        send_byte(8'h89, ack);
        chk("R3", "read address ack", int'(ack), 0);
        send_byte(8'h01, ack);
        bus_stop();
        chk("R3", "vol after read address", int'(vol_att_o), 63);

        // R10: byte cut short by STOP
        bus_start();
        send_byte(8'h88, ack);
        send_bits(8'h00, 4);
        bus_stop();
        chk("R10", "vol after truncated byte", int'(vol_att_o), 63);

        // R10: byte cut short by repeated START, then a full write
        bus_start();
        send_byte(8'h88, ack);
        send_bits(8'h00, 5);
        bus_start();
        send_byte(8'h88, ack);
        chk("R11", "ack after repeated start", int'(ack), 1);
        send_byte(8'h10, ack);
        bus_stop();
        chk("R10", "vol after start-cut byte", int'(vol_att_o), 16);
        chk("R11", "sda released after stop", int'(sda_pull_o), 0);

        // R11: repeated START between two writes
        bus_start();
        send_byte(8'h88, ack);
        send_byte(8'h01, ack);
        bus_start();
        send_byte(8'h88, ack);
        send_byte(8'h0C, ack);
        bus_stop();
        chk("R11", "vol after second segment", int'(vol_att_o), 12);

        // R4: several bytes in one transaction
        bus_start();
        send_byte(8'h88, ack);
        send_byte(8'h05, ack);
        chk("R4", "ack byte 1", int'(ack), 1);
        send_byte(8'h6F, ack);
        chk("R4", "ack byte 2", int'(ack), 1);
        send_byte(8'h77, ack);
        chk("R4", "ack byte 3", int'(ack), 1);
        bus_stop();
        chk("R4", "vol", int'(vol_att_o), 5);
        chk("R9", "bass 1111", int'(bass_o), 0);
        chk("R9", "treble 0111", int'(treble_o), 0);
        chk("R6", "RF untouched", int'(spk_att_o[9:5]), 20);

        finish_run();
    end

endmodule